// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the sequencer on the transmit side of an Ethernet DMA engine. It follows a ring of descriptors in system memory. Each descriptor is 16 bytes long. The walker reads the ownership and status word, the control and size word, and the buffer address word. For every descriptor it finds owned by hardware, it sends one read request (buffer address, byte count, first/last segment marks) to a packet-data mover. When the segment's data has been moved, and for the last segment of a frame also once transmission completes, it writes status back into the descriptor. That write clears the ownership bit and hands the descriptor back to software. It then moves on to the next descriptor, or returns to the ring base after a descriptor flagged as the end of the ring.

Software programs the ring base while the walker is idle. It starts the walker with a poll-demand pulse, or by raising the transmit DMA enable. When a fetch finds a descriptor still owned by software, the walker raises a "no buffer" status pulse and goes idle. It keeps pointing at that same descriptor and fetches it again on the next poll. Memory is reached through a single-word request/acknowledge port with one access outstanding at a time.

The controller states are IDLE, RD_CTRL (fetch word 0), RD_SIZE (fetch word 1), RD_BUF (fetch word 2), ISSUE (offer the request to the mover), MOVE (wait for the data move), WAIT_FRM (wait for frame completion), WRITE_BACK (store word 0) and ADVANCE (step the pointer). The transitions are:
- IDLE to RD_CTRL on a start.
- RD_CTRL to RD_SIZE on an acknowledge with the ownership bit set, or RD_CTRL to IDLE when that bit is clear.
- RD_SIZE to RD_BUF, and RD_BUF to ISSUE, on acknowledge.
- ISSUE to MOVE when the mover accepts.
- MOVE to WAIT_FRM (last segment) or MOVE to WRITE_BACK (other segments) on move done.
- WAIT_FRM to WRITE_BACK on frame done.
- WRITE_BACK to ADVANCE on acknowledge.
- ADVANCE to RD_CTRL while DMA stays enabled, otherwise ADVANCE to IDLE.

Top module: `tdw_walker`

## Requirements
- R1: After reset the walker is idle: no memory request, no mover request, and no status or interrupt pulse.
- R2: A start occurs on a poll pulse while DMA is enabled, or on the rising edge of the DMA enable. A poll while DMA is disabled causes no memory access.
- R3: A walk reads word 0 at pointer P, then word 1 at P+4, then word 2 at P+8, all word aligned. If bit 31 of word 0 is clear, the walker pulses the no-buffer status, issues no mover request and goes idle with P unchanged, so the next start fetches P again.
- R4: The mover request carries word 2 as the address, word 1 bits 10:0 as the byte count, word 1 bit 28 as first segment and bit 27 as last segment. The request is held stable until accepted.
- R5: After a segment without the last mark has been moved, word 0 is rewritten as zero. For a last segment, the walker waits for frame completion and writes word 0 with bit 0 set to the late-collision result, bit 1 to the excess-collision result, and bit 31 cleared.
- R6: After write back, the pointer becomes P+16, or the ring base when word 1 bit 31 is set. The walk then continues with the next fetch while DMA is enabled.
- R7: Each completed segment move produces one moved-status pulse. The FIFO interrupt pulses with it only when word 1 bit 29 is set.
- R8: The sent interrupt pulses once after a last segment's write back, and only when word 1 bit 30 is set.
- R9: Writing the ring base while idle sets the pointer to that base.
- R10: At most one memory access is outstanding. A request keeps its address and direction until acknowledged, and is never raised while a mover request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en_i | input | 1 | Transmit DMA enable level |
| poll_i | input | 1 | Poll-demand pulse |
| base_we_i | input | 1 | Ring base write strobe |
| base_i | input | AW | Ring base byte address |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Word address in bytes |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access complete; read data valid |
| mem_rdata_i | input | 32 | Read data |
| rd_valid_o | output | 1 | Mover request valid |
| rd_ready_i | input | 1 | Mover accepts request |
| rd_addr_o | output | AW | Buffer address |
| rd_len_o | output | LW | Buffer byte count |
| rd_first_o | output | 1 | First segment of frame |
| rd_last_o | output | 1 | Last segment of frame |
| mv_done_i | input | 1 | Segment data moved to FIFO |
| frm_done_i | input | 1 | Frame transmission finished |
| frm_late_col_i | input | 1 | Frame aborted by late collision |
| frm_exc_col_i | input | 1 | Frame aborted after excess collisions |
| sts_moved_o | output | 1 | Data-moved status pulse |
| sts_nobuf_o | output | 1 | No-buffer status pulse |
| irq_fifo_o | output | 1 | Per-descriptor moved interrupt pulse |
| irq_sent_o | output | 1 | Per-descriptor sent interrupt pulse |

## Verification
The assertions check several properties on every cycle: memory and mover request stability until their handshakes, no overlap between a memory access and a mover request, word alignment, ownership always cleared in write-back data, and no mover request alongside a no-buffer pulse. The bench scenarios are needed to show the ordering of fetches, pointer advance and ring wrap, and re-fetching after a no-buffer stop. They also show the collision bits written back, the per-descriptor interrupt selection, and that a poll with DMA disabled is ignored.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
    localparam int WORD_W = 32;

    // word 0 fields
    localparam int OWN_BIT   = 31;
    localparam int LATE_BIT  = 0;
    localparam int EXC_BIT   = 1;
    // word 1 fields
    localparam int EOR_BIT   = 31;
    localparam int ISENT_BIT = 30;
    localparam int IFIFO_BIT = 29;
    localparam int FIRST_BIT = 28;
    localparam int LAST_BIT  = 27;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_CTRL,
        ST_RD_SIZE,
        ST_RD_BUF,
        ST_ISSUE,
        ST_MOVE,
        ST_WAIT_FRM,
        ST_WRITE_BACK,
        ST_ADVANCE
    } tdw_state_e;

    typedef struct packed {
        logic eor;
        logic irq_sent;
        logic irq_fifo;
        logic first;
        logic last;
    } tdw_flags_t;
endpackage

// File: rtl/tdw_trig.sv
module tdw_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en_i,
    input  logic poll_i,
    output logic start_o
);
    logic en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= dma_en_i;
    end

    assign start_o = dma_en_i & (poll_i | ~en_q);
endmodule

// File: rtl/tdw_ptr.sv
module tdw_ptr #(
    parameter int AW     = 32,
    parameter int STRIDE = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we_i,
    input  logic [AW-1:0] base_i,
    input  logic          idle_i,
    input  logic          step_i,
    input  logic          wrap_i,
    output logic [AW-1:0] cur_o
);
    localparam logic [AW-1:0] STEP = AW'(STRIDE);

    logic [AW-1:0] base_q;
    logic [AW-1:0] cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else begin
            if (base_we_i) base_q <= base_i;
            if (base_we_i && idle_i) cur_q <= base_i;
            else if (step_i)         cur_q <= wrap_i ? base_q : cur_q + STEP;
        end
    end

    assign cur_o = cur_q;
endmodule

// File: rtl/tdw_ctrl.sv
module tdw_ctrl
    import tdw_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dma_en_i,
    input  logic [AW-1:0]     cur_i,
    output logic              idle_o,
    output logic              step_o,
    output logic              wrap_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              rd_valid_o,
    input  logic              rd_ready_i,
    output logic [AW-1:0]     rd_addr_o,
    output logic [LW-1:0]     rd_len_o,
    output logic              rd_first_o,
    output logic              rd_last_o,
    input  logic              mv_done_i,
    input  logic              frm_done_i,
    input  logic              frm_late_col_i,
    input  logic              frm_exc_col_i,
    output logic              sts_moved_o,
    output logic              sts_nobuf_o,
    output logic              irq_fifo_o,
    output logic              irq_sent_o
);
    localparam logic [AW-1:0] OFS_SIZE = AW'(4);
    localparam logic [AW-1:0] OFS_BUF  = AW'(8);

    tdw_state_e  state_q, state_d;
    tdw_flags_t  flags_q;
    logic [LW-1:0] len_q;
    logic [AW-1:0] buf_q;
    logic late_q, exc_q;
    logic moved_q, nobuf_q, fifo_q, sent_q;

    logic unused_rdata;
    assign unused_rdata = ^{mem_rdata_i[26:LW], mem_rdata_i[30:0]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_i) state_d = ST_RD_CTRL;
            ST_RD_CTRL:    if (mem_ack_i)
                               state_d = mem_rdata_i[OWN_BIT] ? ST_RD_SIZE : ST_IDLE;
            ST_RD_SIZE:    if (mem_ack_i) state_d = ST_RD_BUF;
            ST_RD_BUF:     if (mem_ack_i) state_d = ST_ISSUE;
            ST_ISSUE:      if (rd_ready_i) state_d = ST_MOVE;
            ST_MOVE:       if (mv_done_i)
                               state_d = flags_q.last ? ST_WAIT_FRM : ST_WRITE_BACK;
            ST_WAIT_FRM:   if (frm_done_i) state_d = ST_WRITE_BACK;
            ST_WRITE_BACK: if (mem_ack_i) state_d = ST_ADVANCE;
            ST_ADVANCE:    state_d = dma_en_i ? ST_RD_CTRL : ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // descriptor capture, collision results and status pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            len_q   <= '0;
            buf_q   <= '0;
            late_q  <= 1'b0;
            exc_q   <= 1'b0;
            moved_q <= 1'b0;
            nobuf_q <= 1'b0;
            fifo_q  <= 1'b0;
            sent_q  <= 1'b0;
        end else begin
            moved_q <= 1'b0;
            nobuf_q <= 1'b0;
            fifo_q  <= 1'b0;
            sent_q  <= 1'b0;
            if (state_q == ST_RD_CTRL && mem_ack_i && !mem_rdata_i[OWN_BIT])
                nobuf_q <= 1'b1;
            if (state_q == ST_RD_SIZE && mem_ack_i) begin
                flags_q.eor      <= mem_rdata_i[EOR_BIT];
                flags_q.irq_sent <= mem_rdata_i[ISENT_BIT];
                flags_q.irq_fifo <= mem_rdata_i[IFIFO_BIT];
                flags_q.first    <= mem_rdata_i[FIRST_BIT];
                flags_q.last     <= mem_rdata_i[LAST_BIT];
                len_q            <= mem_rdata_i[LW-1:0];
            end
            if (state_q == ST_RD_BUF && mem_ack_i)
                buf_q <= AW'(mem_rdata_i);
            if (state_q == ST_ISSUE) begin
                late_q <= 1'b0;
                exc_q  <= 1'b0;
            end
            if (state_q == ST_MOVE && mv_done_i) begin
                moved_q <= 1'b1;
                fifo_q  <= flags_q.irq_fifo;
            end
            if (state_q == ST_WAIT_FRM && frm_done_i) begin
                late_q <= frm_late_col_i;
                exc_q  <= frm_exc_col_i;
            end
            if (state_q == ST_WRITE_BACK && mem_ack_i)
                sent_q <= flags_q.last & flags_q.irq_sent;
        end
    end

    // outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = cur_i;
        mem_wdata_o = '0;
        rd_valid_o  = 1'b0;
        step_o      = 1'b0;
        idle_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:       idle_o = 1'b1;
            ST_RD_CTRL:    mem_req_o = 1'b1;
            ST_RD_SIZE: begin
                mem_req_o  = 1'b1;
                mem_addr_o = cur_i + OFS_SIZE;
            end
            ST_RD_BUF: begin
                mem_req_o  = 1'b1;
                mem_addr_o = cur_i + OFS_BUF;
            end
            ST_ISSUE:      rd_valid_o = 1'b1;
            ST_MOVE:       ;
            ST_WAIT_FRM:   ;
            ST_WRITE_BACK: begin
                mem_req_o              = 1'b1;
                mem_we_o               = 1'b1;
                mem_wdata_o[LATE_BIT]  = late_q;
                mem_wdata_o[EXC_BIT]   = exc_q;
            end
            ST_ADVANCE:    step_o = 1'b1;
            default:       ;
        endcase
    end

    assign wrap_o      = flags_q.eor;
    assign rd_addr_o   = buf_q;
    assign rd_len_o    = len_q;
    assign rd_first_o  = flags_q.first;
    assign rd_last_o   = flags_q.last;
    assign sts_moved_o = moved_q;
    assign sts_nobuf_o = nobuf_q;
    assign irq_fifo_o  = fifo_q;
    assign irq_sent_o  = sent_q;
endmodule

// File: rtl/tdw_walker.sv
module tdw_walker
    import tdw_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LW     = 11,
    parameter int STRIDE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en_i,
    input  logic              poll_i,
    input  logic              base_we_i,
    input  logic [AW-1:0]     base_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              rd_valid_o,
    input  logic              rd_ready_i,
    output logic [AW-1:0]     rd_addr_o,
    output logic [LW-1:0]     rd_len_o,
    output logic              rd_first_o,
    output logic              rd_last_o,
    input  logic              mv_done_i,
    input  logic              frm_done_i,
    input  logic              frm_late_col_i,
    input  logic              frm_exc_col_i,
    output logic              sts_moved_o,
    output logic              sts_nobuf_o,
    output logic              irq_fifo_o,
    output logic              irq_sent_o
);
    logic          start;
    logic          idle;
    logic          step;
    logic          wrap;
    logic [AW-1:0] cur;

    tdw_trig u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .dma_en_i (dma_en_i),
        .poll_i   (poll_i),
        .start_o  (start)
    );

    tdw_ptr #(.AW(AW), .STRIDE(STRIDE)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_we_i (base_we_i),
        .base_i    (base_i),
        .idle_i    (idle),
        .step_i    (step),
        .wrap_i    (wrap),
        .cur_o     (cur)
    );

    tdw_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .dma_en_i       (dma_en_i),
        .cur_i          (cur),
        .idle_o         (idle),
        .step_o         (step),
        .wrap_o         (wrap),
        .mem_req_o      (mem_req_o),
        .mem_we_o       (mem_we_o),
        .mem_addr_o     (mem_addr_o),
        .mem_wdata_o    (mem_wdata_o),
        .mem_ack_i      (mem_ack_i),
        .mem_rdata_i    (mem_rdata_i),
        .rd_valid_o     (rd_valid_o),
        .rd_ready_i     (rd_ready_i),
        .rd_addr_o      (rd_addr_o),
        .rd_len_o       (rd_len_o),
        .rd_first_o     (rd_first_o),
        .rd_last_o      (rd_last_o),
        .mv_done_i      (mv_done_i),
        .frm_done_i     (frm_done_i),
        .frm_late_col_i (frm_late_col_i),
        .frm_exc_col_i  (frm_exc_col_i),
        .sts_moved_o    (sts_moved_o),
        .sts_nobuf_o    (sts_nobuf_o),
        .irq_fifo_o     (irq_fifo_o),
        .irq_sent_o     (irq_sent_o)
    );
endmodule

// File: rtl/tdw_walker_chk.sv
module tdw_walker_chk #(
    parameter int AW = 32,
    parameter int LW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic          mem_ack_i,
    input logic [AW-1:0] mem_addr_o,
    input logic [31:0]   mem_wdata_o,
    input logic          rd_valid_o,
    input logic          rd_ready_i,
    input logic [AW-1:0] rd_addr_o,
    input logic [LW-1:0] rd_len_o,
    input logic          sts_nobuf_o
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R10
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && rd_valid_o)); // R10
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> mem_addr_o[1:0] == 2'b00); // R3
    AST_MOVER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o) && $stable(rd_len_o)); // R4
    AST_WB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o |-> !mem_wdata_o[31]); // R5
    AST_NOBUF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sts_nobuf_o |-> !rd_valid_o && !mem_we_o); // R3
endmodule

bind tdw_walker tdw_walker_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_ack_i   (mem_ack_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .rd_valid_o  (rd_valid_o),
    .rd_ready_i  (rd_ready_i),
    .rd_addr_o   (rd_addr_o),
    .rd_len_o    (rd_len_o),
    .sts_nobuf_o (sts_nobuf_o)
);

// File: tb/tdw_walker_bench.sv
module tdw_walker_bench;
    localparam int AW = 32;
    localparam int LW = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dma_en = 1'b0, poll = 1'b0, base_we = 1'b0;
    logic [AW-1:0] base = '0;
    logic mem_req, mem_we, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;
    logic rd_valid, rd_first, rd_last;
    logic [AW-1:0] rd_addr;
    logic [LW-1:0] rd_len;
    logic mv_done = 1'b0, frm_done = 1'b0, late_cfg = 1'b0, exc_cfg = 1'b0;
    logic sts_moved, sts_nobuf, irq_fifo, irq_sent;

    always #5 clk = ~clk;

    tdw_walker u_tdw_walker (
        .clk(clk), .rst_n(rst_n), .dma_en_i(dma_en), .poll_i(poll),
        .base_we_i(base_we), .base_i(base),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .rd_valid_o(rd_valid), .rd_ready_i(1'b1), .rd_addr_o(rd_addr),
        .rd_len_o(rd_len), .rd_first_o(rd_first), .rd_last_o(rd_last),
        .mv_done_i(mv_done), .frm_done_i(frm_done),
        .frm_late_col_i(late_cfg), .frm_exc_col_i(exc_cfg),
        .sts_moved_o(sts_moved), .sts_nobuf_o(sts_nobuf),
        .irq_fifo_o(irq_fifo), .irq_sent_o(irq_sent)
    );

    int n_checks = 0, n_fail = 0;
    logic [31:0] mem [0:511];
    int n_reads = 0;
    logic [AW-1:0] last_rd_addr = '0;
    logic [AW-1:0] log_addr [0:7];
    logic [LW-1:0] log_len [0:7];
    logic log_first [0:7];
    logic log_last [0:7];
    int n_mv = 0;
    int c_moved = 0, c_fifo = 0, c_sent = 0, c_nobuf = 0;
    int mv_cd = 0, fr_cd = 0;
    logic mv_busy = 1'b0, seg_last = 1'b0;

    // memory responder, mover and frame models, monitors
    always @(negedge clk) begin
        mv_done  <= 1'b0;
        frm_done <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
            else begin
                mem_rdata    <= mem[mem_addr[10:2]];
                n_reads      <= n_reads + 1;
                last_rd_addr <= mem_addr;
            end
        end else mem_ack <= 1'b0;
        if (rd_valid && !mv_busy) begin
            if (n_mv < 8) begin
                log_addr[n_mv]  <= rd_addr;
                log_len[n_mv]   <= rd_len;
                log_first[n_mv] <= rd_first;
                log_last[n_mv]  <= rd_last;
            end
            n_mv     <= n_mv + 1;
            mv_busy  <= 1'b1;
            mv_cd    <= 3;
            seg_last <= rd_last;
        end else if (mv_busy) begin
            if (mv_cd == 1) begin
                mv_done <= 1'b1;
                mv_busy <= 1'b0;
                if (seg_last) fr_cd <= 3;
            end
            mv_cd <= mv_cd - 1;
        end
        if (fr_cd != 0) begin
            if (fr_cd == 1) frm_done <= 1'b1;
            fr_cd <= fr_cd - 1;
        end
        if (sts_moved) c_moved <= c_moved + 1;
        if (irq_fifo)  c_fifo  <= c_fifo + 1;
        if (irq_sent)  c_sent  <= c_sent + 1;
        if (sts_nobuf) c_nobuf <= c_nobuf + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < 512; i++) mem[i] = '0;
        n_reads = 0; n_mv = 0;
        c_moved = 0; c_fifo = 0; c_sent = 0; c_nobuf = 0;
    endtask

    function automatic logic [31:0] w1(input logic eor, input logic isent, input logic ififo,
                                       input logic first, input logic last, input int len);
        return {eor, isent, ififo, first, last, 16'h0, len[10:0]};
    endfunction

    task automatic put_desc(input int addr, input logic own, input logic [31:0] ctl, input logic [31:0] buf_a);
        mem[addr/4]     = {own, 31'h0};
        mem[addr/4 + 1] = ctl;
        mem[addr/4 + 2] = buf_a;
    endtask

    task automatic set_base(input logic [AW-1:0] b);
        @(negedge clk); base = b; base_we = 1'b1;
        @(negedge clk); base_we = 1'b0;
    endtask

    task automatic do_poll();
        @(negedge clk); poll = 1'b1;
        @(negedge clk); poll = 1'b0;
    endtask

    task automatic wait_nobuf(input int target);
        for (int i = 0; i < 600; i++) begin
            if (c_nobuf >= target) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 idle mem_req", 32'(mem_req), 0);
        chk("R1 idle rd_valid", 32'(rd_valid), 0);
        chk("R1 no pulses", 32'({sts_moved, sts_nobuf, irq_fifo, irq_sent}), 0);
    endtask

    task automatic t_disabled_poll();
        clear_all();
        put_desc(32'h100, 1'b1, w1(0,1,0,1,1,100), 32'h2000);
        set_base(32'h100);
        do_poll();
        repeat (20) @(negedge clk);
        chk("R2 poll while disabled: reads", 32'(n_reads), 0);
        chk("R2 poll while disabled: owner kept", mem[32'h100/4], 32'h8000_0000);
    endtask

    task automatic t_enable_start();
        // continues from t_disabled_poll: descriptor at 0x100 prepared, DMA off
        @(negedge clk); dma_en = 1'b1;
        wait_nobuf(1);
        chk("R2 rising enable starts walk", 32'(n_mv), 1);
        chk("R4 mover addr", log_addr[0], 32'h2000);
        chk("R4 mover len", 32'(log_len[0]), 100);
        chk("R4 first/last", 32'({log_first[0], log_last[0]}), 32'b11);
        chk("R5 write back clean", mem[32'h100/4], 0);
        chk("R3 fetch order word count", 32'(n_reads), 4);
        chk("R6 next fetch at P+16", last_rd_addr, 32'h110);
        chk("R8 sent irq", 32'(c_sent), 1);
        chk("R7 fifo irq absent", 32'(c_fifo), 0);
        chk("R7 moved status", 32'(c_moved), 1);
    endtask

    task automatic t_collision(input logic late, input logic exc, input logic [31:0] exp);
        clear_all();
        late_cfg = late; exc_cfg = exc;
        put_desc(32'h200, 1'b1, w1(0,0,0,1,1,64), 32'h3000);
        set_base(32'h200);
        do_poll();
        wait_nobuf(1);
        chk("R5 collision status word", mem[32'h200/4], exp);
        chk("R8 sent irq not requested", 32'(c_sent), 0);
        late_cfg = 1'b0; exc_cfg = 1'b0;
    endtask

    task automatic t_multi_seg();
        clear_all();
        late_cfg = 1'b1;
        put_desc(32'h300, 1'b1, w1(0,0,1,1,0,200), 32'h4000);
        put_desc(32'h310, 1'b1, w1(0,0,1,0,0,300), 32'h4100);
        put_desc(32'h320, 1'b1, w1(0,1,1,0,1,40),  32'h4200);
        set_base(32'h300);
        do_poll();
        wait_nobuf(1);
        chk("R4 three segments", 32'(n_mv), 3);
        chk("R4 seg0 marks", 32'({log_first[0], log_last[0]}), 32'b10);
        chk("R4 seg1 marks", 32'({log_first[1], log_last[1]}), 32'b00);
        chk("R4 seg2 marks", 32'({log_first[2], log_last[2]}), 32'b01);
        chk("R4 seg1 addr", log_addr[1], 32'h4100);
        chk("R5 middle segment released", mem[32'h310/4], 0);
        chk("R5 last segment late col", mem[32'h320/4], 32'h1);
        chk("R7 fifo irq per segment", 32'(c_fifo), 3);
        chk("R8 sent once per frame", 32'(c_sent), 1);
        late_cfg = 1'b0;
    endtask

    task automatic t_wrap();
        clear_all();
        put_desc(32'h400, 1'b1, w1(0,0,0,1,1,10), 32'h5000);
        put_desc(32'h410, 1'b1, w1(1,0,0,1,1,20), 32'h5100);
        mem[32'h420/4] = 32'h8000_0000;
        set_base(32'h400);
        do_poll();
        wait_nobuf(1);
        chk("R6 two frames before wrap", 32'(n_mv), 2);
        chk("R6 wrapped to base", last_rd_addr, 32'h400);
        chk("R6 read count", 32'(n_reads), 7);
        chk("R6 slot past ring end untouched", mem[32'h420/4], 32'h8000_0000);
    endtask

    task automatic t_nobuf_refetch();
        clear_all();
        put_desc(32'h600, 1'b0, w1(0,1,0,1,1,77), 32'h6000);
        set_base(32'h600);
        do_poll();
        wait_nobuf(1);
        chk("R3 no-buffer pulse", 32'(c_nobuf), 1);
        chk("R3 no mover request", 32'(n_mv), 0);
        chk("R3 single word read", 32'(n_reads), 1);
        mem[32'h600/4] = 32'h8000_0000;
        do_poll();
        wait_nobuf(2);
        chk("R3 same descriptor refetched", 32'(n_mv), 1);
        chk("R9 base addr served", log_addr[0], 32'h6000);
        chk("R9 len", 32'(log_len[0]), 77);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled_poll();
        t_enable_start();
        t_collision(1'b1, 1'b0, 32'h1);
        t_collision(1'b0, 1'b1, 32'h2);
        t_multi_seg();
        t_wrap();
        t_nobuf_refetch();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule